// File: doc/BRIEF.md
# Palette DAC Write Port

This block is the register-side front end of a 256-entry colour lookup table. Software talks to it through a 16-byte window on a simple 32-bit register bus. It writes an entry number into an address register. It then writes the red, green and blue intensities one after another into a single colour register. Each colour write comes out of the block as one strobe on a palette write port (entry, channel, 8-bit value). The pixel composer's palette storage receives that strobe. A one-cycle refresh pulse follows each strobe, so the display pipeline knows it must redraw the whole frame.

The block keeps an internal phase (red, green, blue). It steps this phase on every colour write. After the blue write the entry number advances by one, wrapping from 255 to 0, so a whole palette loads as a stream of colour writes. The intensity is always the most significant byte of the bus word.

After reset the block walks through all 256 entries, one per cycle. It sets each entry to black, except the last entry, which it sets to full white. During this walk the bus ready signal stays low. Reads return zero throughout.

Top module: `palette_dac_port`

## Requirements
- R1: A full-word write to offset 0x0 loads the entry number from bus bits 31:24 and returns the colour phase to red. It produces no palette strobe, even when it lands in the middle of a colour triple.
- R2: A full-word write to offset 0x4 produces, in the cycle after it is accepted, one palette strobe. The strobe carries the current entry number and the current channel, and its value is bus bits 31:24.
- R3: Successive colour writes target the channels in the order red (code 0), green (code 1), blue (code 2). After blue the order starts again at red.
- R4: The colour write that targets blue advances the entry number by one, modulo 256, so entry 255 is followed by entry 0.
- R5: Every read in the window returns zero and changes no state.
- R6: From reset until the end of the init walk, bus ready is low. In the 256 cycles after reset release, the palette port strobes entries 0 to 255 in order, with channel code 3 (all three channels at once). Each strobe carries value 0x00, except entry 255, which carries 0xFF.
- R7: A write is ignored when any of these holds: it goes to offset 0x8 or 0xC, it goes to a non-word-aligned offset, it has a byte enable other than 4'b1111, or it arrives while ready is low. An ignored write changes neither the entry number nor the phase.
- R8: The refresh output pulses high for exactly one cycle, in the cycle after each bus-originated palette strobe. It does not pulse for init-walk strobes.
- R9: Reset sets the entry number to 0 and the phase to red, so the first colour write after the init walk targets entry 0, red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request in the 16-byte window |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is a valid access |
| bus_wdata | input | 32 | Write data; bits 31:24 are used |
| bus_rdata | output | 32 | Read data, always zero |
| bus_ready | output | 1 | Low while the init walk runs |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | 8 | Palette entry number |
| pal_chan | output | 2 | 0 red, 1 green, 2 blue, 3 all channels |
| pal_val | output | 8 | Intensity value |
| refresh | output | 1 | One-cycle full-redraw request |

## Verification
The embedded properties take three things for granted about the inputs. Reset is held low for at least one clock edge. The bus master treats ready as a plain gate and does not expect a retry of a write it made while ready was low. Bus inputs hold known values around each rising edge. The bench drives every input on the falling edge and holds reset for several cycles. It deliberately issues writes during the init walk and with bad offsets or partial byte enables, and expects them to be dropped rather than stalled. Random traffic in the bench uses only defined values.

// File: rtl/pdac_pkg.sv
// Shared definitions for the palette DAC write port.
// Assumes a 16-byte register window addressed by byte offset.
package pdac_pkg;

    // Channel code carried on the palette write port.
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GREEN = 2'd1,
        CH_BLUE  = 2'd2,
        CH_ALL   = 2'd3
    } chan_e;

    localparam int WIN_AW = 4;
    localparam logic [WIN_AW-1:0] OFS_INDEX = 4'h0;
    localparam logic [WIN_AW-1:0] OFS_COLOR = 4'h4;

endpackage

// File: rtl/pdac_bus_decode.sv
// Decodes bus writes into index-load and colour-load requests.
// Assumes the window is WIN_AW bits wide; only full-word writes while
// ready is high are accepted; all other accesses are dropped.
module pdac_bus_decode
    import pdac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  sel,
    input  logic                  wr,
    input  logic [WIN_AW-1:0]     addr,
    input  logic [DATA_W/8-1:0]   be,
    input  logic                  ready,
    output logic                  idx_wr,
    output logic                  col_wr
);
    logic accept;

    // Accept only complete word writes while the block is ready.
    always_comb begin
        accept = sel && wr && ready && (&be);
        idx_wr = accept && (addr == OFS_INDEX);
        col_wr = accept && (addr == OFS_COLOR);
    end

endmodule

// File: rtl/pdac_color_seq.sv
// Holds the entry number and colour phase, and turns colour loads into
// registered palette strobes followed by a one-cycle refresh pulse.
// Assumes idx_wr and col_wr are never high together.
module pdac_color_seq
    import pdac_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             col_wr,
    input  logic [IDX_W-1:0] new_idx,
    input  logic [VAL_W-1:0] new_val,
    output logic             st_we,
    output logic [IDX_W-1:0] st_idx,
    output chan_e            st_chan,
    output logic [VAL_W-1:0] st_val,
    output logic             refresh
);
    logic [IDX_W-1:0] cur_idx;
    chan_e            phase;

    // Track entry number and channel phase across index and colour loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
            phase   <= CH_RED;
        end else if (idx_wr) begin
            cur_idx <= new_idx;
            phase   <= CH_RED;
        end else if (col_wr) begin
            case (phase)
                CH_RED:   phase <= CH_GREEN;
                CH_GREEN: phase <= CH_BLUE;
                default: begin
                    phase   <= CH_RED;
                    cur_idx <= cur_idx + 1'b1;
                end
            endcase
        end
    end

    // Register one palette strobe per accepted colour load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_we   <= 1'b0;
            st_idx  <= '0;
            st_chan <= CH_RED;
            st_val  <= '0;
        end else begin
            st_we <= col_wr;
            if (col_wr) begin
                st_idx  <= cur_idx;
                st_chan <= phase;
                st_val  <= new_val;
            end
        end
    end

    // Request a full redraw one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) refresh <= 1'b0;
        else        refresh <= st_we;
    end

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        phase != CH_ALL);                                                  // R3
    AST_IDX_LOAD_RED: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (phase == CH_RED));                                     // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (col_wr && phase == CH_BLUE) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1))); // R4
    AST_STROBE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        col_wr |=> (st_we && st_chan == $past(phase)));                    // R2
    AST_REFRESH_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> refresh);                                                // R8
    AST_REFRESH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !st_we |=> !refresh);                                              // R8

endmodule

// File: rtl/pdac_init_sweep.sv
// Walks every palette entry once after reset: black everywhere, white
// on the last entry. Busy stays high until the last entry is issued.
module pdac_init_sweep #(
    parameter int IDX_W = 8,
    parameter int VAL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             busy,
    output logic [IDX_W-1:0] sw_idx,
    output logic [VAL_W-1:0] sw_val
);
    localparam logic [IDX_W-1:0] LAST_IDX = '1;

    logic [IDX_W-1:0] cnt;

    // Step the entry counter once per cycle until the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (cnt == LAST_IDX) busy <= 1'b0;
            else                 cnt  <= cnt + 1'b1;
        end
    end

    // Drive the current entry and its initial intensity.
    always_comb begin
        sw_idx = cnt;
        sw_val = (cnt == LAST_IDX) ? '1 : '0;
    end

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || cnt == IDX_W'($past(cnt) + 1'b1)));             // R6
    AST_SWEEP_STAYS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);                                                  // R6

endmodule

// File: rtl/palette_dac_port.sv
// Palette DAC write port: bus decode, colour sequencer and reset walk,
// merged onto one palette write port. Reads always return zero.
// Assumes DATA_W is a multiple of 8 and wider than IDX_W and VAL_W.
module palette_dac_port
    import pdac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int VAL_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_ready,
    output logic                pal_we,
    output logic [IDX_W-1:0]    pal_idx,
    output logic [1:0]          pal_chan,
    output logic [VAL_W-1:0]    pal_val,
    output logic                refresh
);
    localparam int TOP_W = (IDX_W > VAL_W) ? IDX_W : VAL_W;

    logic             sweep_busy;
    logic [IDX_W-1:0] sw_idx;
    logic [VAL_W-1:0] sw_val;
    logic             idx_wr;
    logic             col_wr;
    logic             seq_we;
    logic [IDX_W-1:0] seq_idx;
    chan_e            seq_chan;
    logic [VAL_W-1:0] seq_val;
    logic             unused_low_bits;

    assign unused_low_bits = ^bus_wdata[DATA_W-TOP_W-1:0];

    pdac_init_sweep #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (sweep_busy),
        .sw_idx (sw_idx),
        .sw_val (sw_val)
    );

    pdac_bus_decode #(.DATA_W(DATA_W)) u_decode (
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .be     (bus_be),
        .ready  (bus_ready),
        .idx_wr (idx_wr),
        .col_wr (col_wr)
    );

    pdac_color_seq #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_wr  (idx_wr),
        .col_wr  (col_wr),
        .new_idx (bus_wdata[DATA_W-1 -: IDX_W]),
        .new_val (bus_wdata[DATA_W-1 -: VAL_W]),
        .st_we   (seq_we),
        .st_idx  (seq_idx),
        .st_chan (seq_chan),
        .st_val  (seq_val),
        .refresh (refresh)
    );

    // Bus side: ready follows the walk, reads are always zero.
    always_comb begin
        bus_ready = !sweep_busy;
        bus_rdata = '0;
    end

    // Palette port: the reset walk owns the port until it finishes.
    always_comb begin
        if (sweep_busy) begin
            pal_we   = 1'b1;
            pal_idx  = sw_idx;
            pal_chan = CH_ALL;
            pal_val  = sw_val;
        end else begin
            pal_we   = seq_we;
            pal_idx  = seq_idx;
            pal_chan = seq_chan;
            pal_val  = seq_val;
        end
    end

    AST_BUS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_busy |-> !seq_we);                                           // R7

endmodule

// File: tb/test_palette_dac_port.sv
module test_palette_dac_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        pal_we;
    logic [7:0]  pal_idx;
    logic [1:0]  pal_chan;
    logic [7:0]  pal_val;
    logic        refresh;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    palette_dac_port i_palette_dac_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .pal_we(pal_we),
        .pal_idx(pal_idx), .pal_chan(pal_chan), .pal_val(pal_val),
        .refresh(refresh)
    );

    task automatic check(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Behavioural reference model, advanced on every rising edge.
    bit m_busy = 1;
    int m_cnt = 0, m_idx = 0, m_ph = 0;
    bit m_swe = 0, m_ref = 0;
    int m_sidx = 0, m_sch = 0, m_sval = 0;

    always @(posedge clk) begin
        bit acc;
        int top;
        if (!rst_n) begin
            m_busy = 1; m_cnt = 0; m_idx = 0; m_ph = 0; m_swe = 0; m_ref = 0;
        end else begin
            m_ref = m_swe;
            acc = bus_sel && bus_wr && !m_busy && (bus_be == 4'hF);
            top = int'(bus_wdata[31:24]);
            m_swe = 0;
            if (acc && bus_addr == 4'h0) begin
                m_idx = top; m_ph = 0;
            end else if (acc && bus_addr == 4'h4) begin
                m_swe = 1; m_sidx = m_idx; m_sch = m_ph; m_sval = top;
                if (m_ph == 2) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
                else m_ph = m_ph + 1;
            end
            if (m_busy) begin
                if (m_cnt == 255) m_busy = 0;
                else m_cnt = m_cnt + 1;
            end
        end
    end

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(m_busy ? "R6" : "R7", "ready", bus_ready, !m_busy);
            check("R5", "rdata", bus_rdata, 0);
            if (m_busy) begin
                check("R6", "walk strobe", pal_we, 1);
                check("R6", "walk entry", pal_idx, m_cnt);
                check("R6", "walk channel", pal_chan, 3);
                check("R6", "walk value", pal_val, (m_cnt == 255) ? 255 : 0);
            end else begin
                check("R2", "strobe", pal_we, m_swe);
                if (m_swe) begin
                    check("R4", "entry", pal_idx, m_sidx);
                    check("R3", "channel", pal_chan, m_sch);
                    check("R2", "value", pal_val, m_sval);
                end
            end
            check("R8", "refresh", refresh, m_ref);
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = 4'hF;
        #1 check("R5", "read data", bus_rdata, 0);
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic expect_strobe(string tag, int idx, int ch, int val);
        check(tag, "strobe present", pal_we, 1);
        check(tag, "strobe entry", pal_idx, idx);
        check(tag, "strobe channel", pal_chan, ch);
        check(tag, "strobe value", pal_val, val);
    endtask

    task automatic expect_quiet(string tag);
        check(tag, "no strobe", pal_we, 0);
    endtask

    task automatic wait_ready();
        while (!bus_ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6", "ready in reset", bus_ready, 0);
        rst_n = 1;
        // R7: write during the init walk must be dropped
        bus_write(4'h4, 32'h5A00_0000, 4'hF);
        wait_ready();
        // R9: first colour write after walk goes to entry 0, red
        bus_write(4'h4, 32'hAB00_0000, 4'hF);
        expect_strobe("R9", 0, 0, 8'hAB);
        @(negedge clk);
        check("R8", "refresh after strobe", refresh, 1);
        // R1: index load, no strobe
        bus_write(4'h0, 32'h1000_0000, 4'hF);
        expect_quiet("R1");
        bus_write(4'h4, 32'h1100_0000, 4'hF);
        expect_strobe("R3", 8'h10, 0, 8'h11);
        bus_write(4'h4, 32'h2200_0000, 4'hF);
        expect_strobe("R3", 8'h10, 1, 8'h22);
        bus_write(4'h4, 32'h3300_0000, 4'hF);
        expect_strobe("R3", 8'h10, 2, 8'h33);
        bus_write(4'h4, 32'h44FF_FFFF, 4'hF);
        expect_strobe("R4", 8'h11, 0, 8'h44);
        // R1: index load mid-triple resets phase
        bus_write(4'h0, 32'h2000_0000, 4'hF);
        bus_write(4'h4, 32'h5500_0000, 4'hF);
        expect_strobe("R1", 8'h20, 0, 8'h55);
        // R4: wrap from 255 to 0
        bus_write(4'h0, 32'hFF00_0000, 4'hF);
        bus_write(4'h4, 32'h0100_0000, 4'hF);
        bus_write(4'h4, 32'h0200_0000, 4'hF);
        bus_write(4'h4, 32'h0300_0000, 4'hF);
        expect_strobe("R4", 8'hFF, 2, 8'h03);
        bus_write(4'h4, 32'h6600_0000, 4'hF);
        expect_strobe("R4", 0, 0, 8'h66);
        // R7: ignored accesses
        bus_write(4'h8, 32'h7700_0000, 4'hF);
        expect_quiet("R7");
        bus_write(4'hC, 32'h7700_0000, 4'hF);
        expect_quiet("R7");
        bus_write(4'h5, 32'h7700_0000, 4'hF);
        expect_quiet("R7");
        bus_write(4'h4, 32'h7700_0000, 4'h3);
        expect_quiet("R7");
        bus_write(4'h0, 32'h3000_0000, 4'h8);
        expect_quiet("R7");
        bus_read(4'h4);
        bus_read(4'h0);
        bus_write(4'h4, 32'h7700_0000, 4'hF);
        expect_strobe("R7", 0, 1, 8'h77);
        // Random traffic checked by the model
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            bus_sel = 1'($urandom);
            bus_wr = 1'($urandom);
            case ($urandom % 4)
                0: bus_addr = 4'h0;
                1, 2: bus_addr = 4'h4;
                default: bus_addr = 4'($urandom);
            endcase
            bus_be = (($urandom % 8) == 0) ? 4'($urandom) : 4'hF;
            bus_wdata = $urandom;
        end
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
        // R9: reset mid-operation restores entry 0 red
        rst_n = 0;
        repeat (2) @(negedge clk);
        check("R6", "ready in second reset", bus_ready, 0);
        rst_n = 1;
        wait_ready();
        bus_write(4'h4, 32'hC300_0000, 4'hF);
        expect_strobe("R9", 0, 0, 8'hC3);
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule